// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table held in memory. The page size is 4 KB. The top ten address bits select an entry in the root table. That entry names the physical page that holds one second-level table. The next ten bits select an entry in that page, and the entry found there names the physical frame. The low twelve bits pass through unchanged as the offset inside the frame.

A requester supplies the address with a one-cycle request strobe while the walker is idle. The walker then makes two dependent reads on a single memory read port. Each read is a one-cycle request pulse, and the walker waits any number of cycles for the matching response. A clear valid bit at either level stops the walk and reports a fault. Only one walk runs at a time, and a busy flag covers it. The root table's byte base address is an input. It is sampled when a request is accepted.

The controller uses six named states. IDLE accepts a request and moves to FETCH_ROOT, which issues the root read and moves to AWAIT_ROOT. A valid root response leads to FETCH_LEAF, and an invalid one returns to IDLE with a fault reported. FETCH_LEAF issues the leaf read and moves to AWAIT_LEAF. A valid leaf response leads to FINISH, and an invalid one returns to IDLE with a fault reported. FINISH returns to IDLE after one cycle.

Top module: `ptw_two_level`

## Requirements
- R1: While reset is held and on the first cycle after it, busy_o, done_o and mem_req_o are 0.
- R2: A request is accepted only when busy_o is 0, and busy_o is 1 in the following cycle. A request strobe seen while busy_o is 1 causes no extra memory read and does not change the result of the walk in progress.
- R3: The first memory read is issued one cycle after acceptance. Its address is the sampled root base plus 4 times the root index, where the root index is vaddr[31:22].
- R4: A root entry is valid when bit 0 is 1. If the root entry is invalid, the walk ends with done_o=1, fault_o=1 and busy_o=0 in the cycle after the response, and no second read is issued.
- R5: After a valid root response, the second read is issued in the next cycle. Its address is {root_entry[31:12], vaddr[21:12], 2'b00}. Entry bits 11:1 have no effect.
- R6: If the leaf entry's bit 0 is 0, the walk ends with done_o=1 and fault_o=1 in the cycle after the response.
- R7: On a valid leaf entry, done_o=1 and fault_o=0 in the cycle after the response. frame_o equals leaf_entry[31:12], and paddr_o equals {frame_o, vaddr[11:0]}.
- R8: done_o is a pulse of exactly one cycle. For a successful walk, busy_o is still 1 during that cycle and is 0 in the cycle after it.
- R9: Each level issues exactly one read pulse, whatever the response latency. The walker holds its wait state until mem_rvalid_i is 1.
- R10: A new request presented in the same cycle that a fault is reported is accepted. busy_o is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| root_base_i | input | 32 | Byte address of the root table |
| req_valid_i | input | 1 | Walk request strobe |
| req_vaddr_i | input | 32 | Logical address to translate |
| busy_o | output | 1 | A walk is in progress |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response entry |
| done_o | output | 1 | Walk result pulse |
| fault_o | output | 1 | Walk ended on an invalid entry |
| frame_o | output | 20 | Translated frame number |
| paddr_o | output | 32 | Translated physical address |

## Verification
A fault ends the walk back in IDLE. The fault report therefore falls in the same cycle as the first cycle in which a new request can be accepted. The bench starts a walk whose root entry is invalid and waits for the fault pulse. It drives a fresh request in that same cycle. The check passes if the fault is reported with busy low, busy is high one cycle later, and the new walk completes with its own correct frame. Strobes driven during a running walk also meet the result cycle. The bench counts memory read pulses to show that these strobes were ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_FETCH_ROOT = 3'd1,
        ST_AWAIT_ROOT = 3'd2,
        ST_FETCH_LEAF = 3'd3,
        ST_AWAIT_LEAF = 3'd4,
        ST_FINISH     = 3'd5
    } walk_state_e;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        req_valid_i,
    input  logic        rsp_valid_i,
    input  logic        entry_ok_i,
    output walk_state_e state_o,
    output logic        ev_accept_o,
    output logic        ev_root_ok_o,
    output logic        ev_leaf_ok_o,
    output logic        ev_fault_o
);

    walk_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and walk events
    always_comb begin
        state_d      = state_q;
        ev_accept_o  = 1'b0;
        ev_root_ok_o = 1'b0;
        ev_leaf_ok_o = 1'b0;
        ev_fault_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    ev_accept_o = 1'b1;
                    state_d     = ST_FETCH_ROOT;
                end
            end
            ST_FETCH_ROOT: state_d = ST_AWAIT_ROOT;
            ST_AWAIT_ROOT: begin
                if (rsp_valid_i) begin
                    if (entry_ok_i) begin
                        ev_root_ok_o = 1'b1;
                        state_d      = ST_FETCH_LEAF;
                    end else begin
                        ev_fault_o = 1'b1;
                        state_d    = ST_IDLE;
                    end
                end
            end
            ST_FETCH_LEAF: state_d = ST_AWAIT_LEAF;
            ST_AWAIT_LEAF: begin
                if (rsp_valid_i) begin
                    if (entry_ok_i) begin
                        ev_leaf_ok_o = 1'b1;
                        state_d      = ST_FINISH;
                    end else begin
                        ev_fault_o = 1'b1;
                        state_d    = ST_IDLE;
                    end
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

    // R9
    hold_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_AWAIT_ROOT && !rsp_valid_i) |=> state_q == ST_AWAIT_ROOT);

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    parameter int PTE_W  = 32
) (
    input  walk_state_e              state_i,
    input  logic [ADDR_W-1:0]        vaddr_i,
    input  logic [ADDR_W-1:0]        root_i,
    input  logic [ADDR_W-OFF_W-1:0]  table_pg_i,
    output logic                     mem_req_o,
    output logic [ADDR_W-1:0]        mem_addr_o
);

    localparam int NUM_W  = ADDR_W - OFF_W;
    localparam int ROOT_W = NUM_W - IDX_W;
    localparam int SH     = $clog2(PTE_W / 8);

    logic [ROOT_W-1:0] root_idx;
    logic [IDX_W-1:0]  leaf_idx;
    logic [ADDR_W-1:0] root_addr;
    logic [ADDR_W-1:0] leaf_addr;
    logic              unused_off;

    assign root_idx   = vaddr_i[ADDR_W-1 -: ROOT_W];
    assign leaf_idx   = vaddr_i[OFF_W +: IDX_W];
    assign unused_off = ^vaddr_i[OFF_W-1:0];

    assign root_addr = root_i + (ADDR_W'(root_idx) << SH);

    generate
        if (IDX_W + SH == OFF_W) begin : g_leaf_concat
            assign leaf_addr = {table_pg_i, leaf_idx, {SH{1'b0}}};
        end else begin : g_leaf_add
            assign leaf_addr = {table_pg_i, {OFF_W{1'b0}}} + (ADDR_W'(leaf_idx) << SH);
        end
    endgenerate

    always_comb begin
        mem_req_o  = 1'b0;
        mem_addr_o = root_addr;
        unique case (state_i)
            ST_FETCH_ROOT: begin
                mem_req_o  = 1'b1;
                mem_addr_o = root_addr;
            end
            ST_FETCH_LEAF: begin
                mem_req_o  = 1'b1;
                mem_addr_o = leaf_addr;
            end
            ST_AWAIT_LEAF, ST_FINISH: mem_addr_o = leaf_addr;
            default: mem_addr_o = root_addr;
        endcase
    end

endmodule

// File: rtl/ptw_result.sv
module ptw_result #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int PTE_W  = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     ev_accept_i,
    input  logic                     ev_root_ok_i,
    input  logic                     ev_leaf_ok_i,
    input  logic                     ev_fault_i,
    input  logic [ADDR_W-1:0]        req_vaddr_i,
    input  logic [ADDR_W-1:0]        root_base_i,
    input  logic [PTE_W-1:0]         rdata_i,
    output logic [ADDR_W-1:0]        vaddr_o,
    output logic [ADDR_W-1:0]        root_o,
    output logic [ADDR_W-OFF_W-1:0]  table_pg_o,
    output logic                     done_o,
    output logic                     fault_o,
    output logic [ADDR_W-OFF_W-1:0]  frame_o,
    output logic [ADDR_W-1:0]        paddr_o
);

    localparam int NUM_W = ADDR_W - OFF_W;

    logic [NUM_W-1:0] entry_num;
    logic             unused_low;

    assign entry_num  = rdata_i[PTE_W-1 -: NUM_W];
    assign unused_low = ^rdata_i[PTE_W-NUM_W-1:0];

    // request capture
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            vaddr_o    <= '0;
            root_o     <= '0;
            table_pg_o <= '0;
        end else begin
            if (ev_accept_i) begin
                vaddr_o <= req_vaddr_i;
                root_o  <= root_base_i;
            end
            if (ev_root_ok_i) begin
                table_pg_o <= entry_num;
            end
        end
    end

    // registered walk outputs
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            done_o  <= 1'b0;
            fault_o <= 1'b0;
            frame_o <= '0;
            paddr_o <= '0;
        end else begin
            done_o <= ev_leaf_ok_i | ev_fault_i;
            if (ev_fault_i) begin
                fault_o <= 1'b1;
                frame_o <= '0;
                paddr_o <= '0;
            end else if (ev_leaf_ok_i) begin
                fault_o <= 1'b0;
                frame_o <= entry_num;
                paddr_o <= {entry_num, vaddr_o[OFF_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/ptw_two_level.sv
module ptw_two_level
    import ptw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int PTE_W     = 32,
    parameter int VALID_BIT = 0
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [ADDR_W-1:0]        root_base_i,
    input  logic                     req_valid_i,
    input  logic [ADDR_W-1:0]        req_vaddr_i,
    output logic                     busy_o,
    output logic                     mem_req_o,
    output logic [ADDR_W-1:0]        mem_addr_o,
    input  logic                     mem_rvalid_i,
    input  logic [PTE_W-1:0]         mem_rdata_i,
    output logic                     done_o,
    output logic                     fault_o,
    output logic [ADDR_W-OFF_W-1:0]  frame_o,
    output logic [ADDR_W-1:0]        paddr_o
);

    localparam int NUM_W  = ADDR_W - OFF_W;
    localparam int ROOT_W = NUM_W - IDX_W;
    localparam int SH     = $clog2(PTE_W / 8);

    walk_state_e       state;
    logic              ev_accept, ev_root_ok, ev_leaf_ok, ev_fault;
    logic              entry_ok;
    logic [ADDR_W-1:0] vaddr_q, root_q;
    logic [NUM_W-1:0]  table_pg_q;

    assign entry_ok = mem_rdata_i[VALID_BIT];
    assign busy_o   = (state != ST_IDLE);

    ptw_ctrl u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_valid_i  (req_valid_i),
        .rsp_valid_i  (mem_rvalid_i),
        .entry_ok_i   (entry_ok),
        .state_o      (state),
        .ev_accept_o  (ev_accept),
        .ev_root_ok_o (ev_root_ok),
        .ev_leaf_ok_o (ev_leaf_ok),
        .ev_fault_o   (ev_fault)
    );

    ptw_result #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .PTE_W(PTE_W)) u_result (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ev_accept_i  (ev_accept),
        .ev_root_ok_i (ev_root_ok),
        .ev_leaf_ok_i (ev_leaf_ok),
        .ev_fault_i   (ev_fault),
        .req_vaddr_i  (req_vaddr_i),
        .root_base_i  (root_base_i),
        .rdata_i      (mem_rdata_i),
        .vaddr_o      (vaddr_q),
        .root_o       (root_q),
        .table_pg_o   (table_pg_q),
        .done_o       (done_o),
        .fault_o      (fault_o),
        .frame_o      (frame_o),
        .paddr_o      (paddr_o)
    );

    ptw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_W(PTE_W)) u_addr (
        .state_i    (state),
        .vaddr_i    (vaddr_q),
        .root_i     (root_q),
        .table_pg_i (table_pg_q),
        .mem_req_o  (mem_req_o),
        .mem_addr_o (mem_addr_o)
    );

    // R2
    accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !busy_o) |=> (busy_o && mem_req_o));

    // R3
    root_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !busy_o) |=> (mem_addr_o == $past(root_base_i)
            + (ADDR_W'($past(req_vaddr_i[ADDR_W-1 -: ROOT_W])) << SH)));

    // R4
    root_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_AWAIT_ROOT && mem_rvalid_i && !entry_ok)
            |=> (done_o && fault_o && !busy_o && !mem_req_o));

    // R5
    leaf_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_AWAIT_ROOT && mem_rvalid_i && entry_ok)
            |=> (mem_req_o && mem_addr_o[ADDR_W-1:OFF_W] == $past(mem_rdata_i[PTE_W-1 -: NUM_W])));

    // R6
    leaf_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_AWAIT_LEAF && mem_rvalid_i && !entry_ok) |=> (done_o && fault_o));

    // R7
    frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_AWAIT_LEAF && mem_rvalid_i && entry_ok)
            |=> (done_o && !fault_o && frame_o == $past(mem_rdata_i[PTE_W-1 -: NUM_W])
                 && paddr_o[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

    // R8
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9
    single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |=> !mem_req_o);

endmodule

// File: tb/tb_ptw_two_level.sv
`timescale 1ns/1ps
module tb_ptw_two_level;

    localparam logic [31:0] ROOT_A = 32'h0001_0000;
    localparam logic [31:0] ROOT_B = 32'h0007_F000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = ROOT_A;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        busy, mem_req, mem_rvalid, done, fault;
    logic [31:0] mem_addr, mem_rdata, paddr;
    logic [19:0] frame;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int nreq = 0;
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [31:0] addr_l = '0;

    always #2 clk = ~clk;

    ptw_two_level dut (
        .clk_i(clk), .rst_ni(rst_n), .root_base_i(root_base),
        .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .busy_o(busy),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
        .mem_rdata_i(mem_rdata), .done_o(done), .fault_o(fault),
        .frame_o(frame), .paddr_o(paddr)
    );

    function automatic logic [11:0] tbase(input logic [31:0] root);
        return (root == ROOT_B) ? 12'h600 : 12'h100;
    endfunction
    function automatic bit root_ok(input logic [31:0] root, input int o);
        return (root == ROOT_B) ? (o % 7 != 6) : (o % 3 != 2);
    endfunction
    function automatic bit leaf_ok(input int o, input int i);
        return ((o + i) % 5) != 4;
    endfunction
    function automatic logic [19:0] frame_of(input int o, input int i, input int salt);
        return 20'((o * 7 + i * 13 + 5 + salt * 32'h333) & 32'hFFFFF);
    endfunction

    // memory contents computed from the address; bits 11:1 carry junk
    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        int o, i, salt, tp;
        if (a >= root_base && a < root_base + 32'h1000) begin
            o = int'((a - root_base) >> 2);
            return {8'h0, tbase(root_base) + 12'(o), 11'h2A5, root_ok(root_base, o)};
        end
        tp = int'(a >> 12);
        salt = (tp >= 32'h600) ? 1 : 0;
        o = tp - ((salt != 0) ? 32'h600 : 32'h100);
        i = int'((a >> 2) & 32'h3FF);
        return {frame_of(o, i, salt), 11'h55A, leaf_ok(o, i)};
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend) begin
            if (cnt <= 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_fn(addr_l);
                pend       <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (mem_req) begin
            pend   <= 1'b1;
            cnt    <= lat;
            addr_l <= mem_addr;
            nreq   <= nreq + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
    endtask

    task automatic walk(input logic [31:0] va, input bit noise);
        int o, i, salt, n0;
        bit e_fault, seen;
        logic [19:0] e_frame;
        o = int'(va[31:22]); i = int'(va[21:12]);
        salt = (root_base == ROOT_B) ? 1 : 0;
        e_fault = !root_ok(root_base, o) || !leaf_ok(o, i);
        e_frame = frame_of(o, i, salt);
        while (busy) @(negedge clk);
        n0 = nreq;
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        check(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'h1);
        if (noise) req_vaddr = ~va; else req_valid = 1'b0;
        wait_done(seen);
        req_valid = 1'b0;
        check(seen, "R9 walk completes", 32'(seen), 32'h1);
        if (!seen) return;
        check(fault == e_fault, e_fault ? "R4/R6 fault" : "R7 no fault", 32'(fault), 32'(e_fault));
        check((nreq - n0) == (root_ok(root_base, o) ? 2 : 1), "R9 read count",
              32'(nreq - n0), root_ok(root_base, o) ? 32'd2 : 32'd1);
        if (!e_fault) begin
            check(frame == e_frame, "R7 frame", 32'(frame), 32'(e_frame));
            check(paddr == {e_frame, va[11:0]}, "R7 paddr", paddr, {e_frame, va[11:0]});
            check(busy == 1'b1, "R8 busy in result cycle", 32'(busy), 32'h1);
        end
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", 32'(done), 32'h0);
        check(busy == 1'b0, "R8 idle after result", 32'(busy), 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        int n0;
        @(negedge clk);
        check(!busy && !done && !mem_req, "R1 in reset", {busy, done, mem_req}, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_req, "R1 after reset", {busy, done, mem_req}, 32'h0);

        // R3 R5: root and leaf read addresses observed on the port
        req_valid = 1'b1; req_vaddr = 32'hABC5_5123;
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_req && mem_addr == ROOT_A + 32'(10'h2AF) * 4, "R3 root address",
              mem_addr, ROOT_A + 32'(10'h2AF) * 4);
        while (!mem_rvalid) @(negedge clk);
        @(negedge clk);
        check(mem_req && mem_addr == {12'h0, 12'h100 + 12'h2AF, 10'h055, 2'b00}, "R5 leaf address",
              mem_addr, {12'h0, 12'h100 + 12'h2AF, 10'h055, 2'b00});
        wait_done(seen);
        @(negedge clk);

        // near-exhaustive sweep over the root index
        for (int o = 0; o < 1024; o++) begin
            lat = 1 + (o % 3);
            walk({10'(o), 10'((o * 37 + 3) & 1023), 12'(o * 5)}, (o % 4) == 1);
            walk({10'(o), 10'(1023 - o), 12'(4095 - o)}, 1'b0);
        end
        lat = 1;
        walk(32'h0000_0000, 1'b0);
        walk(32'hFFFF_FFFF, 1'b1);

        // second root base
        root_base = ROOT_B;
        for (int o = 0; o < 1024; o += 5) begin
            lat = 1 + (o % 4);
            walk({10'(o), 10'(o ^ 10'h155), 12'hA5A}, 1'b0);
        end

        // R10: new request in the fault-report cycle
        root_base = ROOT_A; lat = 2;
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_vaddr = {10'd2, 10'd1, 12'h123};
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen);
        check(seen && fault && !busy, "R10 fault with busy low", {seen, fault, busy}, 32'h6);
        n0 = nreq;
        req_valid = 1'b1; req_vaddr = {10'd4, 10'd9, 12'h7E1};
        @(negedge clk);
        req_valid = 1'b0;
        check(busy && !done, "R10 accepted in fault cycle", {busy, done}, 32'h2);
        wait_done(seen);
        check(seen && !fault && frame == frame_of(4, 9, 0), "R10 chained walk frame",
              32'(frame), 32'(frame_of(4, 9, 0)));
        check(paddr == {frame_of(4, 9, 0), 12'h7E1}, "R10 chained walk paddr",
              paddr, {frame_of(4, 9, 0), 12'h7E1});
        check(nreq - n0 == 2, "R10 chained read count", 32'(nreq - n0), 32'd2);
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule